// File: doc/BRIEF.md
# Three-Wire Codec Control Write Master

This block sends register writes to an audio codec over a three-wire control bus. It drives three outputs: a framing line (MODE), a bit clock (CLOCK) and a serial data line (DATA). The user side pulses `start_i` for one cycle with an 8-bit register selector and an 8-bit value. The block then sends two bytes. The first is the address byte, made by OR-ing the fixed device address parameter with the selector. The second is the data byte. `busy_o` stays high for the whole transfer, and `done_o` pulses for one cycle when the transfer ends. Every bus timing step lasts one delay phase of `PHASE_CLKS` system clocks.

The sequencer has five named states.
- `ST_IDLE`: the bus sits at its rest levels.
- `ST_LEAD`: CLOCK is held high and MODE is moved to the level that frames the next byte.
- `ST_CLK_LO`: CLOCK is low, and the current bit is on DATA.
- `ST_CLK_HI`: CLOCK is high again, so the codec samples the bit on this rising edge.
- `ST_TRAIL`: MODE is flipped to close the byte.

The transitions are:
- `ST_IDLE` to `ST_LEAD` when start is accepted.
- `ST_LEAD` to `ST_CLK_LO`, and `ST_CLK_LO` to `ST_CLK_HI`, each at the end of a phase.
- `ST_CLK_HI` back to `ST_CLK_LO` while bits remain, or to `ST_TRAIL` after the eighth bit.
- `ST_TRAIL` to `ST_LEAD` for the data byte, or to `ST_IDLE` after the data byte.

Top module: `l3_write_master`

## Requirements
- R1: During and after reset, and whenever `busy_o` is low, MODE and CLOCK are high.
- R2: Each transfer carries exactly 16 bits, sent least significant bit first. Bits 0 to 7 form `DEV_ADDR | reg_sel_i`, and bits 8 to 15 form `wdata_i`. A bit is the DATA level at a rising edge of CLOCK.
- R3: MODE is low for every bit of the address byte and high for every bit of the data byte. MODE never changes while CLOCK is low.
- R4: The address byte starts with `PHASE_CLKS` cycles of MODE low and CLOCK high. Its closing phase has MODE high for `PHASE_CLKS` cycles. The data byte starts with `PHASE_CLKS` cycles of MODE high. Its closing phase has MODE low for `PHASE_CLKS` cycles.
- R5: Every CLOCK low phase lasts exactly `PHASE_CLKS` system cycles. `PHASE_CLKS` may be as small as 1.
- R6: DATA never changes on the edge where CLOCK rises. It holds its value from the start of the low phase through the rising edge.
- R7: `busy_o` rises in the cycle after start is accepted and stays high for exactly 36 × `PHASE_CLKS` cycles.
- R8: `done_o` is high for exactly one cycle per transfer. That cycle is the first cycle in which `busy_o` is low again.
- R9: A start pulse while `busy_o` is high has no effect. It neither restarts nor lengthens the transfer, and it adds no extra `done_o` pulse.
- R10: The selector and data are captured when start is accepted. Later changes on `reg_sel_i` and `wdata_i` do not alter the bytes sent.
- R11: DATA is low after reset and whenever `busy_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | One-cycle request to begin a register write |
| reg_sel_i | input | BYTE_W | Register selector, OR-ed into the device address |
| wdata_i | input | BYTE_W | Value written in the data byte |
| busy_o | output | 1 | High while a transfer is in progress |
| done_o | output | 1 | One-cycle pulse at the end of a transfer |
| l3_mode_o | output | 1 | Byte framing line |
| l3_clk_o | output | 1 | Bus bit clock, idles high |
| l3_data_o | output | 1 | Serial data line |

## Verification
The assertions assume that `PHASE_CLKS` is at least 1 and that reset is released in step with `clk`. They place no limit on when `start_i` may arrive, because a start during a transfer must be dropped rather than forbidden. The stimulus follows the same rule. It sends random and directed selector and data values. It also fires extra start pulses and changes the inputs in the middle of a transfer, so R9 and R10 are tested inside the same legal input space the assertions cover.

// File: rtl/l3w_pkg.sv
package l3w_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_LEAD   = 3'd1,
        ST_CLK_LO = 3'd2,
        ST_CLK_HI = 3'd3,
        ST_TRAIL  = 3'd4
    } l3w_state_e;

    // Framing level for a state; dat_phase is 1 while the data byte is active.
    function automatic logic mode_level(l3w_state_e st, logic dat_phase);
        logic lvl;
        case (st)
            ST_LEAD, ST_CLK_LO, ST_CLK_HI: lvl = dat_phase;
            ST_TRAIL:                      lvl = ~dat_phase;
            default:                       lvl = 1'b1;
        endcase
        return lvl;
    endfunction

endpackage

// File: rtl/l3w_phase_timer.sv
module l3w_phase_timer #(
    parameter int PHASE_CLKS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart_i,
    output logic phase_end_o
);
    generate
        if (PHASE_CLKS <= 1) begin : g_single
            assign phase_end_o = 1'b1;
        end else begin : g_count
            localparam int CW = $clog2(PHASE_CLKS);
            localparam logic [CW-1:0] RELOAD = CW'(PHASE_CLKS - 1);

            logic [CW-1:0] cnt_q;

            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    cnt_q <= RELOAD;
                end else if (restart_i) begin
                    cnt_q <= RELOAD;
                end else if (cnt_q != '0) begin
                    cnt_q <= cnt_q - 1'b1;
                end
            end

            assign phase_end_o = (cnt_q == '0);

            AST_PHASE_COUNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
                cnt_q <= RELOAD); // R5
        end
    endgenerate
endmodule

// File: rtl/l3w_byte_shifter.sv
module l3w_byte_shifter #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [BYTE_W-1:0] load_val_i,
    input  logic              shift_i,
    output logic              lsb_o,
    output logic              all_sent_o
);
    localparam int CNTW = $clog2(BYTE_W + 1);
    localparam logic [CNTW-1:0] LAST = CNTW'(BYTE_W);

    logic [BYTE_W-1:0] sh_q;
    logic [CNTW-1:0]   sent_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q   <= '0;
            sent_q <= '0;
        end else if (load_i) begin
            sh_q   <= load_val_i;
            sent_q <= '0;
        end else if (shift_i) begin
            sh_q   <= {1'b0, sh_q[BYTE_W-1:1]};
            sent_q <= sent_q + 1'b1;
        end
    end

    assign lsb_o      = sh_q[0];
    assign all_sent_o = (sent_q == LAST);

    AST_NO_EXTRA_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        shift_i |-> !all_sent_o); // R2
    AST_SENT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        sent_q <= LAST); // R2
endmodule

// File: rtl/l3_write_master.sv
module l3_write_master
    import l3w_pkg::*;
#(
    parameter int                PHASE_CLKS = 4,
    parameter int                BYTE_W     = 8,
    parameter logic [BYTE_W-1:0] DEV_ADDR   = BYTE_W'(8'h14)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [BYTE_W-1:0] reg_sel_i,
    input  logic [BYTE_W-1:0] wdata_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              l3_mode_o,
    output logic              l3_clk_o,
    output logic              l3_data_o
);
    l3w_state_e        state_q, state_d;
    logic              is_data_q, is_data_d;
    logic [BYTE_W-1:0] hold_q;
    logic              phase_end;
    logic              timer_restart;
    logic              sh_load, sh_shift, sh_lsb, sh_all_sent;
    logic [BYTE_W-1:0] sh_val;
    logic              accept;
    logic              last_end;

    assign accept        = (state_q == ST_IDLE) && start_i;
    assign last_end      = (state_q == ST_TRAIL) && phase_end && is_data_q;
    assign timer_restart = (state_q == ST_IDLE) || phase_end;

    l3w_phase_timer #(.PHASE_CLKS(PHASE_CLKS)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .restart_i  (timer_restart),
        .phase_end_o(phase_end)
    );

    assign sh_load  = accept || ((state_q == ST_TRAIL) && phase_end && !is_data_q);
    assign sh_val   = (state_q == ST_IDLE) ? (DEV_ADDR | reg_sel_i) : hold_q;
    assign sh_shift = (state_q == ST_CLK_LO) && phase_end;

    l3w_byte_shifter #(.BYTE_W(BYTE_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (sh_load),
        .load_val_i(sh_val),
        .shift_i   (sh_shift),
        .lsb_o     (sh_lsb),
        .all_sent_o(sh_all_sent)
    );

    // Next-state logic
    always_comb begin
        state_d   = state_q;
        is_data_d = is_data_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) begin
                    state_d   = ST_LEAD;
                    is_data_d = 1'b0;
                end
            end
            ST_LEAD: begin
                if (phase_end) state_d = ST_CLK_LO;
            end
            ST_CLK_LO: begin
                if (phase_end) state_d = ST_CLK_HI;
            end
            ST_CLK_HI: begin
                if (phase_end) state_d = sh_all_sent ? ST_TRAIL : ST_CLK_LO;
            end
            ST_TRAIL: begin
                if (phase_end) begin
                    if (is_data_q) begin
                        state_d = ST_IDLE;
                    end else begin
                        state_d   = ST_LEAD;
                        is_data_d = 1'b1;
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            is_data_q <= 1'b0;
            hold_q    <= '0;
        end else begin
            state_q   <= state_d;
            is_data_q <= is_data_d;
            if (accept) hold_q <= wdata_i;
        end
    end

    // Registered pin and status outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            l3_mode_o <= 1'b1;
            l3_clk_o  <= 1'b1;
            l3_data_o <= 1'b0;
            done_o    <= 1'b0;
        end else begin
            l3_mode_o <= mode_level(state_d, is_data_d);
            l3_clk_o  <= (state_d != ST_CLK_LO);
            done_o    <= last_end;
            if (state_d == ST_CLK_LO && state_q != ST_CLK_LO) begin
                l3_data_o <= sh_lsb;
            end else if (last_end) begin
                l3_data_o <= 1'b0;
            end
        end
    end

    assign busy_o = (state_q != ST_IDLE);

    AST_IDLE_FRAME_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (l3_mode_o && l3_clk_o)); // R1
    AST_IDLE_DATA_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !l3_data_o); // R11
    AST_MODE_STEADY_CLK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !l3_clk_o |-> $stable(l3_mode_o)); // R3
    AST_DATA_STABLE_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(l3_clk_o) |-> $stable(l3_data_o)); // R6
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R8
    AST_DONE_AT_BUSY_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!busy_o && $past(busy_o))); // R8
endmodule

// File: tb/tb_l3_write_master.sv
module tb_l3_write_master;
    localparam int         P    = 3;
    localparam int         BW   = 8;
    localparam logic [7:0] DEV  = 8'h14;
    localparam int         XFER = 36 * P;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [7:0] sel = '0;
    logic [7:0] wd = '0;
    logic busy, done, mode, sclk, sdat;

    always #10 clk = ~clk;

    l3_write_master #(.PHASE_CLKS(P), .BYTE_W(BW), .DEV_ADDR(DEV)) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .reg_sel_i(sel), .wdata_i(wd),
        .busy_o(busy), .done_o(done), .l3_mode_o(mode), .l3_clk_o(sclk), .l3_data_o(sdat)
    );

    int checks = 0;
    int fails = 0;

    // pin monitor
    bit   mon_en = 1'b0;
    int   cyc, nbits, lo_run, lo_bad, unstable, done_cnt;
    logic prev_clk, prev_dat;
    logic bitv [0:63];
    logic bitm [0:63];
    logic hist_mode [0:255];
    logic hist_clk  [0:255];

    always @(negedge clk) begin
        if (mon_en) begin
            if (done) done_cnt++;
            if (busy) begin
                if (cyc < 256) begin
                    hist_mode[cyc] = mode;
                    hist_clk[cyc]  = sclk;
                end
                cyc++;
            end
            if (!sclk) lo_run++;
            if (sclk && !prev_clk) begin
                if (lo_run != P) lo_bad++;
                if (sdat != prev_dat) unstable++;
                if (nbits < 64) begin
                    bitv[nbits] = sdat;
                    bitm[nbits] = mode;
                end
                nbits++;
                lo_run = 0;
            end
            prev_clk = sclk;
            prev_dat = sdat;
        end
    end

    function automatic logic [7:0] exp_addr(logic [7:0] s);
        return DEV | s;
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic xfer(logic [7:0] s, logic [7:0] d, bit disturb);
        logic [7:0] a_got, d_got;
        int mbad, fbad, w;
        @(posedge clk); #2;
        cyc = 0; nbits = 0; lo_run = 0; lo_bad = 0; unstable = 0; done_cnt = 0;
        prev_clk = sclk; prev_dat = sdat; mon_en = 1'b1;
        sel = s; wd = d; start = 1'b1;
        @(posedge clk); #2;
        start = 1'b0;
        if (disturb) begin
            sel = ~s; wd = ~d;
            repeat (5 * P) @(posedge clk);
            #2 start = 1'b1; sel = s ^ 8'h5a; wd = d ^ 8'hc3;
            @(posedge clk); #2 start = 1'b0;
            repeat (20 * P) @(posedge clk);
            #2 start = 1'b1;
            @(posedge clk); #2 start = 1'b0;
        end
        w = 0;
        while (done_cnt == 0 && w < XFER + 64) begin
            @(posedge clk);
            w++;
        end
        repeat (4) @(posedge clk);
        #2;
        mon_en = 1'b0;
        a_got = '0; d_got = '0; mbad = 0; fbad = 0;
        for (int i = 0; i < 8; i++) begin
            a_got[i] = bitv[i];
            d_got[i] = bitv[i + 8];
            if (bitm[i] !== 1'b0) mbad++;
            if (bitm[i + 8] !== 1'b1) mbad++;
        end
        for (int i = 0; i < P; i++) begin
            if (hist_mode[i] !== 1'b0 || hist_clk[i] !== 1'b1) fbad++;
            if (hist_mode[17*P + i] !== 1'b1 || hist_clk[17*P + i] !== 1'b1) fbad++;
            if (hist_mode[18*P + i] !== 1'b1 || hist_clk[18*P + i] !== 1'b1) fbad++;
            if (hist_mode[35*P + i] !== 1'b0 || hist_clk[35*P + i] !== 1'b1) fbad++;
        end
        check(nbits == 16, "R2 bit count", nbits, 16);
        check(a_got == exp_addr(s), disturb ? "R10 address byte" : "R2 address byte", a_got, exp_addr(s));
        check(d_got == d, disturb ? "R10 data byte" : "R2 data byte", d_got, d);
        check(mbad == 0, "R3 mode per bit", mbad, 0);
        check(fbad == 0, "R4 framing phases", fbad, 0);
        check(lo_bad == 0, "R5 clock low length", lo_bad, 0);
        check(unstable == 0, "R6 data at rise", unstable, 0);
        check(cyc == XFER, disturb ? "R9 busy length" : "R7 busy length", cyc, XFER);
        check(done_cnt == 1, disturb ? "R9 done count" : "R8 done count", done_cnt, 1);
        check(mode && sclk && !busy, "R1 idle levels", {mode, sclk, busy}, 3'b110);
        check(sdat == 1'b0, "R11 idle data", sdat, 0);
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL R7 watchdog actual=timeout expected=completion");
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(posedge clk);
        #2;
        check(mode && sclk, "R1 reset levels", {mode, sclk}, 2'b11);
        check(!sdat && !busy && !done, "R11 reset data", {sdat, busy, done}, 0);
        rst_n = 1'b1;
        repeat (2) @(posedge clk);
        #2;
        check(mode && sclk && !sdat && !busy, "R1 idle after reset", {mode, sclk, sdat, busy}, 4'b1100);
        // directed corners
        xfer(8'h00, 8'h00, 1'b0);
        xfer(8'hff, 8'hff, 1'b0);
        xfer(8'h01, 8'h80, 1'b0);
        xfer(8'h02, 8'h5a, 1'b1);
        xfer(8'h03, 8'ha5, 1'b1);
        // random
        for (int k = 0; k < 10; k++) begin
            xfer(8'($urandom()), 8'($urandom()), 1'(k % 3 == 0));
        end
        summary();
        $finish;
    end
endmodule